// File: doc/BRIEF.md
# SMBus Multi-Source Slave Address Matcher

This block watches an SMBus/I2C bus as a slave and decides, for each transfer, whether the device is being addressed. After a START condition it shifts in the seven address bits and the R/W bit on the rising edges of SCL. It then compares the received address against four candidate sources: one programmable address and three fixed SMBus addresses (alert response, default device, host). Each source has its own enable input and its own sticky match flag. When any enabled source matches, the block pulls SDA low for the ninth (acknowledge) clock and records the transfer direction. When nothing matches, it releases the bus and ignores every later bit until the next START.

Software sees the match flags as a four-bit status vector and clears them with a write-one-to-clear strobe. When clock holding is enabled, the block keeps SCL low after the acknowledge clock until every match flag has been cleared. This gives firmware time to identify which address was hit before the data phase begins.

The bus lines are expected on `scl_i`/`sda_i` already synchronised to `clk`. Each SCL high or low phase must last at least two `clk` cycles.

Top module: `smb_addr_matcher`

## Requirements
- R1: The programmed address `own_addr_i` sets flag bit 0 on a match, and only while `match_en_i[0]` is 1.
- R2: The alert response address 7'h0C sets flag bit 1 on a match, and only while `match_en_i[1]` is 1.
- R3: The default device address 7'h61 sets flag bit 2 on a match, and only while `match_en_i[2]` is 1.
- R4: The host address 7'h08 sets flag bit 3 on a match, and only while `match_en_i[3]` is 1.
- R5: After any enabled match, `sda_low_o` is 1 from the SCL falling edge that follows the eighth frame bit until the next SCL falling edge (the ninth clock).
- R6: When no enabled source matches, `sda_low_o` stays 0 and no flag is set. All further bits, including a byte equal to a valid address frame, are ignored until the next START.
- R7: On a match, `tx_mode_o` takes the received R/W bit (the last bit of the frame; 1 means the slave transmits, 0 means it receives). It keeps that value until the next match.
- R8: Match flags are sticky. A 1 on `flag_clr_i[k]` clears only flag k. Several enabled sources matching the same frame set all of their flags.
- R9: With `stretch_en_i` at 1, `scl_hold_o` is 1 from the end of the acknowledge clock for as long as any match flag is set, and it returns to 0 once all flags are clear.
- R10: A START in the middle of a transfer restarts address reception (repeated START). A STOP returns the block to idle, where bits are ignored.
- R11: After reset, flags, `tx_mode_o`, `sda_low_o` and `scl_hold_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised SCL bus level |
| sda_i | input | 1 | Synchronised SDA bus level |
| own_addr_i | input | 7 | Programmable slave address |
| match_en_i | input | 4 | Enables: 0 programmed, 1 alert, 2 default, 3 host |
| stretch_en_i | input | 1 | Hold SCL after a match until flags are cleared |
| flag_clr_i | input | 4 | Write-one-to-clear strobe per match flag |
| sda_low_o | output | 1 | Drive SDA low (acknowledge) |
| scl_hold_o | output | 1 | Drive SCL low (clock hold) |
| match_flags_o | output | 4 | Sticky match flags, same bit order as the enables |
| tx_mode_o | output | 1 | Direction of the last matched transfer |

## Verification
Each fixed address is sent with its enable on and then off. This separates a comparator that ignores its enable from one that compares against the wrong constant. The programmed address is tried with both R/W values, and it is also set equal to the alert address so that two flags are hit by one frame. That case exposes priority encoding where independent flags are required. A non-matching frame followed by a byte that looks like a valid address frame shows whether the block really ignores bits after a miss. A repeated START and a STOP in the middle of an address check that reception restarts and stops correctly. Partial and full flag clears under clock holding show that the hold waits for every flag, not just the first one cleared.

// File: rtl/smb_match_pkg.sv
package smb_match_pkg;
   localparam int unsigned SMB_ADDR_W = 7;
   localparam int unsigned SRC_CNT    = 4;
   localparam int unsigned SRC_OWN    = 0;
   localparam int unsigned SRC_ALERT  = 1;
   localparam int unsigned SRC_DEFLT  = 2;
   localparam int unsigned SRC_HOST   = 3;

   localparam logic [SMB_ADDR_W-1:0] ALERT_ADDR = 7'h0C;
   localparam logic [SMB_ADDR_W-1:0] DEFLT_ADDR = 7'h61;
   localparam logic [SMB_ADDR_W-1:0] HOST_ADDR  = 7'h08;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ACKW,
      PH_ACK,
      PH_HOLD,
      PH_PASS,
      PH_SKIP
   } phase_t;

   function automatic logic [SMB_ADDR_W-1:0] fixed_addr(input int unsigned idx);
      case (idx)
         SRC_ALERT: fixed_addr = ALERT_ADDR;
         SRC_DEFLT: fixed_addr = DEFLT_ADDR;
         SRC_HOST:  fixed_addr = HOST_ADDR;
         default:   fixed_addr = '0;
      endcase
   endfunction
endpackage

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise_o = !scl_q && scl_i;
   assign scl_fall_o = scl_q && !scl_i;
   assign start_o    = scl_q && scl_i && sda_q && !sda_i;
   assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/smb_addr_shift.sv
module smb_addr_shift #(
   parameter int unsigned FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart_i,
   input  logic               shift_i,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic               full_o
);
   localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         frame_o <= '0;
      end else if (restart_i) begin
         cnt_q   <= '0;
      end else if (shift_i && !full_o) begin
         cnt_q   <= cnt_q + 1'b1;
         frame_o <= {frame_o[FRAME_W-2:0], bit_i};
      end
   end

   assign full_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/smb_addr_cmp.sv
module smb_addr_cmp
   import smb_match_pkg::*;
#(
   parameter int unsigned ADDR_W = SMB_ADDR_W,
   parameter int unsigned N_SRC  = SRC_CNT
) (
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic [N_SRC-1:0]  en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [N_SRC-1:0]  hit_o
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic [ADDR_W-1:0] cand;
      if (i == SRC_OWN) begin : g_prog
         assign cand = own_addr_i;
      end else begin : g_fixed
         assign cand = fixed_addr(i);
      end
      assign hit_o[i] = en_i[i] && (addr_i == cand);
   end
endmodule

// File: rtl/smb_addr_matcher.sv
module smb_addr_matcher
   import smb_match_pkg::*;
#(
   parameter int unsigned ADDR_W      = SMB_ADDR_W,
   parameter int unsigned N_SRC       = SRC_CNT,
   parameter bit          HAS_STRETCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic [N_SRC-1:0]  match_en_i,
   input  logic              stretch_en_i,
   input  logic [N_SRC-1:0]  flag_clr_i,
   output logic              sda_low_o,
   output logic              scl_hold_o,
   output logic [N_SRC-1:0]  match_flags_o,
   output logic              tx_mode_o
);
   localparam int unsigned FRAME_W = ADDR_W + 1;

   if (ADDR_W != SMB_ADDR_W) begin : g_bad_width
      $error("smb_addr_matcher: ADDR_W must be 7");
   end
   if (N_SRC != SRC_CNT) begin : g_bad_src
      $error("smb_addr_matcher: N_SRC must be 4");
   end

   logic scl_rise, scl_fall, start_det, stop_det;
   logic [FRAME_W-1:0] frame;
   logic frame_full;
   logic [N_SRC-1:0] hit;
   logic stretch_ok;
   logic eval;
   phase_t phase_q;

   smb_bus_cond u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   smb_addr_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (start_det),
      .shift_i   (scl_rise && (phase_q == PH_ADDR)),
      .bit_i     (sda_i),
      .frame_o   (frame),
      .full_o    (frame_full)
   );

   smb_addr_cmp #(.ADDR_W(ADDR_W), .N_SRC(N_SRC)) u_cmp (
      .own_addr_i (own_addr_i),
      .en_i       (match_en_i),
      .addr_i     (frame[FRAME_W-1:1]),
      .hit_o      (hit)
   );

   if (HAS_STRETCH) begin : g_stretch
      assign stretch_ok = stretch_en_i;
   end else begin : g_no_stretch
      assign stretch_ok = 1'b0;
   end

   assign eval = (phase_q == PH_ADDR) && frame_full && !start_det && !stop_det;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else if (start_det) begin
         phase_q <= PH_ADDR;
      end else if (stop_det) begin
         phase_q <= PH_IDLE;
      end else begin
         case (phase_q)
            PH_ADDR: if (frame_full) phase_q <= (|hit) ? PH_ACKW : PH_SKIP;
            PH_ACKW: if (scl_fall) phase_q <= PH_ACK;
            PH_ACK:  if (scl_fall) phase_q <= stretch_ok ? PH_HOLD : PH_PASS;
            PH_HOLD: if (!(|match_flags_o)) phase_q <= PH_PASS;
            default: phase_q <= phase_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_flags_o <= '0;
         tx_mode_o     <= 1'b0;
      end else begin
         match_flags_o <= (match_flags_o & ~flag_clr_i) | (eval ? hit : '0);
         if (eval && (|hit)) tx_mode_o <= frame[0];
      end
   end

   assign sda_low_o  = (phase_q == PH_ACK);
   assign scl_hold_o = (phase_q == PH_HOLD) && (|match_flags_o);
endmodule

// File: rtl/smb_addr_matcher_chk.sv
module smb_addr_matcher_chk #(
   parameter int unsigned N_SRC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_i,
   input logic             sda_low_o,
   input logic             scl_hold_o,
   input logic [N_SRC-1:0] match_en_i,
   input logic [N_SRC-1:0] flag_clr_i,
   input logic [N_SRC-1:0] match_flags_o
);
   // R1 R2 R3 R4
   flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (((match_flags_o & ~$past(match_flags_o)) & ~$past(match_en_i)) == '0));

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((($past(match_flags_o) & ~match_flags_o) & ~$past(flag_clr_i)) == '0));

   // R5
   ack_starts_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_low_o) |-> !scl_i);

   // R9
   hold_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_hold_o) |-> $past(sda_low_o));

   // R9
   hold_ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold_o |-> !sda_low_o);
endmodule

bind smb_addr_matcher smb_addr_matcher_chk #(.N_SRC(N_SRC)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_i         (scl_i),
   .sda_low_o     (sda_low_o),
   .scl_hold_o    (scl_hold_o),
   .match_en_i    (match_en_i),
   .flag_clr_i    (flag_clr_i),
   .match_flags_o (match_flags_o)
);

// File: tb/smb_addr_matcher_tb_top.sv
module smb_addr_matcher_tb_top;
   typedef struct packed {
      logic       ack;
      logic [3:0] flags;
      logic       tx;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [6:0] own_addr = 7'h3A;
   logic [3:0] match_en = 4'h0;
   logic stretch_en = 1'b0;
   logic [3:0] flag_clr = 4'h0;
   logic sda_low, scl_hold, tx_mode;
   logic [3:0] flags;
   logic scl_bus, sda_bus;
   logic ack_seen;

   int checks = 0;
   int errors = 0;
   exp_t exp_q[$];
   event chk_ev;
   logic [3:0] m_flags = 4'h0;
   logic m_tx = 1'b0;

   always #10 clk = ~clk;

   assign scl_bus = scl_m & ~scl_hold;
   assign sda_bus = sda_m & ~sda_low;

   smb_addr_matcher dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_bus),
      .sda_i         (sda_bus),
      .own_addr_i    (own_addr),
      .match_en_i    (match_en),
      .stretch_en_i  (stretch_en),
      .flag_clr_i    (flag_clr),
      .sda_low_o     (sda_low),
      .scl_hold_o    (scl_hold),
      .match_flags_o (flags),
      .tx_mode_o     (tx_mode)
   );

   always @(posedge clk) if (sda_low) ack_seen <= 1'b1;

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] model_hit(input logic [6:0] a);
      logic [3:0] h;
      h[0] = match_en[0] && (a == own_addr);
      h[1] = match_en[1] && (a == 7'h0C);
      h[2] = match_en[2] && (a == 7'h61);
      h[3] = match_en[3] && (a == 7'h08);
      return h;
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_start();
      sda_m = 1'b1; wait_clk(2); scl_m = 1'b1; wait_clk(4);
      sda_m = 1'b0; wait_clk(4); scl_m = 1'b0; wait_clk(4);
   endtask

   task automatic send_stop();
      sda_m = 1'b0; wait_clk(4); scl_m = 1'b1; wait_clk(4);
      sda_m = 1'b1; wait_clk(4);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wait_clk(4); scl_m = 1'b1; wait_clk(4); scl_m = 1'b0; wait_clk(2);
   endtask

   // driver: pushes expected acknowledge/flags/direction, then drives a frame
   task automatic frame(input logic [6:0] a, input logic rw);
      logic [3:0] h;
      h = model_hit(a);
      m_flags = m_flags | h;
      if (|h) m_tx = rw;
      exp_q.push_back('{ack: |h, flags: m_flags, tx: m_tx});
      send_start();
      for (int i = 6; i >= 0; i--) send_bit(a[i]);
      send_bit(rw);
      sda_m = 1'b1; wait_clk(4);
      -> chk_ev;
      wait_clk(1);
      scl_m = 1'b1; wait_clk(4); scl_m = 1'b0; wait_clk(4);
   endtask

   task automatic clear(input logic [3:0] b);
      flag_clr = b; wait_clk(1); flag_clr = 4'h0; wait_clk(2);
      m_flags = m_flags & ~b;
   endtask

   // monitor: compares DUT outputs during the ninth clock against the queue
   initial begin
      forever begin
         exp_t e;
         @(chk_ev);
         e = exp_q.pop_front();
         check(sda_low == e.ack, "R5/R6 ack", {7'b0, sda_low}, {7'b0, e.ack});
         check(flags == e.flags, "R1-R4/R8 flags", {4'b0, flags}, {4'b0, e.flags});
         check(tx_mode == e.tx, "R7 direction", {7'b0, tx_mode}, {7'b0, e.tx});
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      // R11 reset state
      check(flags == 4'h0 && !sda_low && !scl_hold && !tx_mode, "R11 reset",
            {flags, sda_low, scl_hold, tx_mode, 1'b0}, 8'h00);

      // R1 programmed address, write then read
      match_en = 4'b0001;
      frame(7'h3A, 1'b0); send_stop();
      clear(4'b0001);
      check(flags == 4'h0, "R8 clear bit 0", {4'b0, flags}, 8'h00);
      frame(7'h3A, 1'b1); send_stop(); clear(4'b0001);
      match_en = 4'b0000;
      frame(7'h3A, 1'b0); send_stop();              // R1 disabled

      // R2 alert response address
      match_en = 4'b0010;
      frame(7'h0C, 1'b1); send_stop();
      match_en = 4'b0000;
      frame(7'h0C, 1'b0); send_stop();              // R2 disabled: tx stays 1

      // R3 default, R4 host; flags accumulate (R8)
      match_en = 4'b1100;
      frame(7'h61, 1'b0); send_stop();
      frame(7'h08, 1'b1); send_stop();
      clear(4'b0100);
      check(flags == 4'b1010, "R8 partial clear", {4'b0, flags}, 8'h0A);
      clear(4'b1010);
      match_en = 4'b0000;
      frame(7'h61, 1'b0); send_stop();              // R3 disabled
      frame(7'h08, 1'b0); send_stop();              // R4 disabled

      // R8 two sources on one frame
      own_addr = 7'h0C; match_en = 4'b0011;
      frame(7'h0C, 1'b0); send_stop();
      clear(4'b0011);

      // R6 miss, then an address-like byte without START is ignored
      own_addr = 7'h3A; match_en = 4'b1111;
      frame(7'h55, 1'b0);
      ack_seen = 1'b0;
      for (int i = 7; i >= 0; i--) send_bit(8'h18 >> i);
      sda_m = 1'b1; wait_clk(4); scl_m = 1'b1; wait_clk(4); scl_m = 1'b0; wait_clk(4);
      check(!ack_seen && flags == 4'h0, "R6 ignore after miss",
            {3'b0, ack_seen, flags}, 8'h00);
      // R10 repeated START then a match
      frame(7'h08, 1'b0); send_stop();
      clear(4'b1000);

      // R10 STOP mid-address, following bits ignored
      ack_seen = 1'b0;
      send_start();
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
      send_stop();
      scl_m = 1'b0; wait_clk(2);
      for (int i = 7; i >= 0; i--) send_bit(8'h10 >> i);
      sda_m = 1'b1; wait_clk(4); scl_m = 1'b1; wait_clk(4); scl_m = 1'b0; wait_clk(4);
      check(!ack_seen && flags == 4'h0, "R10 idle after STOP",
            {3'b0, ack_seen, flags}, 8'h00);
      scl_m = 1'b1; wait_clk(4);

      // R9 clock hold until every flag is cleared
      stretch_en = 1'b1;
      own_addr = 7'h0C; match_en = 4'b0011;
      frame(7'h0C, 1'b1);
      check(scl_hold == 1'b1, "R9 hold after ack", {7'b0, scl_hold}, 8'h01);
      clear(4'b0001);
      check(scl_hold == 1'b1, "R9 hold with one flag left", {7'b0, scl_hold}, 8'h01);
      clear(4'b0010);
      wait_clk(2);
      check(scl_hold == 1'b0, "R9 release", {7'b0, scl_hold}, 8'h00);
      send_stop();
      stretch_en = 1'b0;

      wait_clk(10);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule